// File: doc/BRIEF.md
# LED Sink Driver Serial Front End

This block is the digital side of a sixteen-channel LED sink driver. A host sends channel on/off data one bit at a time on a serial data line, with a serial clock. A rising edge on a latch strobe moves the sixteen shifted bits into the on/off latch that drives the channel enables. On the same strobe, the shift register can be refilled with the driver's six fault flags, so that the host can shift them back out on the serial output.

A static blank-mode configuration bit sets the role of the BLANK input. With the bit set, BLANK is an output enable: high turns every channel off. With the bit clear, BLANK picks the shift-register bit that feeds the serial output: bit 7 when BLANK is low, bit 15 otherwise. Latching an all-off pattern raises a power-save indication, and the next serial clock edge drops it.

All serial-side pins are asynchronous to the system clock. Each one passes through a two-stage synchroniser, and the strobes are edge-detected in the system clock domain.

Top module: `ledsink_frontend`

## Requirements
- R1: While reset is high and after it is released, `drv_o`, `psave_o`, `sdo_o` and the shift register are all zero.
- R2: Each rising edge of `sclk_i` shifts the register by one place toward bit 15 and puts the level of `sdi_i` into bit 0. After sixteen edges, the first bit sent is in bit 15.
- R3: A rising edge of `lat_i` copies the shift register into the on/off latch. With outputs enabled, `drv_o[n]` then equals latch bit n.
- R4: On a rising edge of `lat_i` with `stat_sel_i`=1, the shift register is loaded with `flags_i` in bits 5:0 and zeros in bits 15:6. The flag order is bit 0 open LED, bit 1 shorted LED, bit 2 output leakage, bit 3 shorted reference pin, bit 4 pre-thermal warning, bit 5 thermal error. With `stat_sel_i`=0, the register keeps its contents.
- R5: When `blank_mode_i`=0 and `blank_i` is low, `sdo_o` follows shift-register bit 7. In all other cases it follows bit 15.
- R6: When `blank_mode_i`=1, `blank_i` high forces `drv_o` to zero and `blank_i` low restores the latched pattern. When `blank_mode_i`=0, `blank_i` has no effect on `drv_o`.
- R7: A latch strobe that commits all-zero data sets `psave_o`. The next rising edge of `sclk_i` clears it, and a strobe that commits nonzero data also clears it. If both strobes rise in the same cycle, the latch strobe wins.
- R8: Only a rising edge acts. Holding `sclk_i` high for many system cycles gives exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdi_i | input | 1 | Serial data in |
| lat_i | input | 1 | Latch strobe |
| blank_i | input | 1 | Output enable or serial-output tap select |
| blank_mode_i | input | 1 | 1: BLANK is output enable; 0: BLANK selects the tap |
| stat_sel_i | input | 1 | 1: load flags into the shift register on the latch strobe |
| flags_i | input | 6 | Fault flag inputs |
| sdo_o | output | 1 | Serial data out |
| drv_o | output | 16 | Registered per-channel sink enables |
| psave_o | output | 1 | Power-save indication |

## Verification
The checker tests the following relations on every cycle:
- a shift edge moves the register by one place and takes in the synchronised data bit;
- a latch edge copies the register into the on/off latch, and either loads the flags or keeps the register;
- the power-save flag is set and cleared as R7 describes;
- `drv_o` is never wider than the latch;
- a blanked output is zero.

Only the bench scenarios can show the serial view end to end:
- words written serially and read back in order;
- the bit-7 and bit-15 tap under each BLANK and mode combination;
- flag placement read out serially;
- a long-held SCLK level giving exactly one shift.

// File: rtl/ledfe_pkg.sv
package ledfe_pkg;
  localparam int unsigned FLAG_COUNT = 6;

  typedef enum logic [2:0] {
    FLG_OPEN   = 3'd0,
    FLG_SHORT  = 3'd1,
    FLG_LEAK   = 3'd2,
    FLG_REFSH  = 3'd3,
    FLG_PREHOT = 3'd4,
    FLG_HOT    = 3'd5
  } flag_idx_e;
endpackage

// File: rtl/ledfe_sync.sv
module ledfe_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/ledfe_shift_core.sv
module ledfe_shift_core #(
  parameter int unsigned CH     = 16,
  parameter int unsigned TAP_LO = 7,
  parameter int unsigned NFLAG  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             sdi,
  input  logic             load_en,
  input  logic             stat_sel,
  input  logic [NFLAG-1:0] flags,
  input  logic             tap_lo_sel,
  output logic [CH-1:0]    sh_o,
  output logic             sdo_o
);
  logic [CH-1:0] sh_q;
  logic [CH-1:0] status_word;

  always_comb begin
    status_word = '0;
    status_word[NFLAG-1:0] = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (load_en) begin
      if (stat_sel) sh_q <= status_word;
    end else if (shift_en) begin
      sh_q <= {sh_q[CH-2:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sdo_o <= 1'b0;
    else     sdo_o <= tap_lo_sel ? sh_q[TAP_LO] : sh_q[CH-1];
  end

  assign sh_o = sh_q;
endmodule

// File: rtl/ledfe_out_stage.sv
module ledfe_out_stage #(
  parameter int unsigned CH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic [CH-1:0] word_i,
  input  logic          enable,
  input  logic          psave_clr,
  output logic [CH-1:0] latch_o,
  output logic [CH-1:0] drv_o,
  output logic          psave_o
);
  logic [CH-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      psave_o <= 1'b0;
    end else if (commit) begin
      latch_q <= word_i;
      psave_o <= (word_i == '0);
    end else if (psave_clr) begin
      psave_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drv_o <= '0;
    else     drv_o <= latch_q & {CH{enable}};
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/ledsink_frontend.sv
module ledsink_frontend #(
  parameter int unsigned CH          = 16,
  parameter int unsigned TAP_LO      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NFLAG       = ledfe_pkg::FLAG_COUNT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic             lat_i,
  input  logic             blank_i,
  input  logic             blank_mode_i,
  input  logic             stat_sel_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic             sdo_o,
  output logic [CH-1:0]    drv_o,
  output logic             psave_o
);
  localparam int unsigned NSYNC = 4;

  logic [NSYNC-1:0] pins_s;
  logic             sclk_s, lat_s, sdi_s, blank_s;
  logic             sclk_d, lat_d;
  logic             sclk_rise, lat_rise;
  logic [CH-1:0]    sh_q;
  logic [CH-1:0]    latch_q;
  logic             out_en, tap_lo_sel;

  ledfe_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({blank_i, sdi_i, lat_i, sclk_i}),
    .sync_o  (pins_s)
  );

  assign {blank_s, sdi_s, lat_s, sclk_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      lat_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      lat_d  <= lat_s;
    end
  end

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign lat_rise   = lat_s & ~lat_d;
  assign out_en     = ~(blank_mode_i & blank_s);
  assign tap_lo_sel = ~blank_mode_i & ~blank_s;

  ledfe_shift_core #(.CH(CH), .TAP_LO(TAP_LO), .NFLAG(NFLAG)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (sclk_rise),
    .sdi        (sdi_s),
    .load_en    (lat_rise),
    .stat_sel   (stat_sel_i),
    .flags      (flags_i),
    .tap_lo_sel (tap_lo_sel),
    .sh_o       (sh_q),
    .sdo_o      (sdo_o)
  );

  ledfe_out_stage #(.CH(CH)) u_out (
    .clk       (clk),
    .rst       (rst),
    .commit    (lat_rise),
    .word_i    (sh_q),
    .enable    (out_en),
    .psave_clr (sclk_rise),
    .latch_o   (latch_q),
    .drv_o     (drv_o),
    .psave_o   (psave_o)
  );
endmodule

// File: rtl/ledsink_frontend_chk.sv
module ledsink_frontend_chk #(
  parameter int unsigned CH    = 16,
  parameter int unsigned NFLAG = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             sclk_rise,
  input logic             lat_rise,
  input logic             sdi_s,
  input logic             blank_s,
  input logic             blank_mode_i,
  input logic             stat_sel_i,
  input logic [NFLAG-1:0] flags_i,
  input logic [CH-1:0]    sh_q,
  input logic [CH-1:0]    latch_q,
  input logic [CH-1:0]    drv_o,
  input logic             psave_o
);
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    sclk_rise && !lat_rise |=> sh_q == {$past(sh_q[CH-2:0]), $past(sdi_s)}); // R2

  AST_LAT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    lat_rise |=> latch_q == $past(sh_q)); // R3

  AST_DRV_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (drv_o & ~$past(latch_q)) == '0); // R3

  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (rst)
    lat_rise && stat_sel_i |=> (sh_q[NFLAG-1:0] == $past(flags_i)) && (sh_q[CH-1:NFLAG] == '0)); // R4

  AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (rst)
    lat_rise && !stat_sel_i |=> $stable(sh_q)); // R4

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (rst)
    blank_mode_i && blank_s |=> drv_o == '0); // R6

  AST_PSAVE_SET: assert property (@(posedge clk) disable iff (rst)
    lat_rise && (sh_q == '0) |=> psave_o); // R7

  AST_PSAVE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    sclk_rise && !lat_rise |=> !psave_o); // R7
endmodule

bind ledsink_frontend ledsink_frontend_chk #(.CH(CH), .NFLAG(NFLAG)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sclk_rise    (sclk_rise),
  .lat_rise     (lat_rise),
  .sdi_s        (sdi_s),
  .blank_s      (blank_s),
  .blank_mode_i (blank_mode_i),
  .stat_sel_i   (stat_sel_i),
  .flags_i      (flags_i),
  .sh_q         (sh_q),
  .latch_q      (latch_q),
  .drv_o        (drv_o),
  .psave_o      (psave_o)
);

// File: tb/ledsink_frontend_tb_top.sv
module ledsink_frontend_tb_top;
  localparam int CH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_i = 0, sdi_i = 0, lat_i = 0, blank_i = 0;
  logic blank_mode_i = 1'b1, stat_sel_i = 1'b0;
  logic [5:0] flags_i = 6'b101101;
  logic sdo_o, psave_o;
  logic [CH-1:0] drv_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  ledsink_frontend dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdi_i(sdi_i), .lat_i(lat_i),
    .blank_i(blank_i), .blank_mode_i(blank_mode_i), .stat_sel_i(stat_sel_i),
    .flags_i(flags_i), .sdo_o(sdo_o), .drv_o(drv_o), .psave_o(psave_o)
  );

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdi_i = b; sclk_i = 1'b1; gap(4);
    sclk_i = 1'b0; gap(4);
  endtask

  task automatic write_word(input logic [CH-1:0] w);
    for (int i = CH - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_lat();
    lat_i = 1'b1; gap(4);
    lat_i = 1'b0; gap(4);
  endtask

  task automatic read_word(output logic [CH-1:0] w);
    for (int i = CH - 1; i >= 0; i--) begin
      w[i] = sdo_o;
      shift_bit(1'b0);
    end
  endtask

  task automatic t_reset();
    check("R1 drv", drv_o, 0);
    check("R1 psave", psave_o, 0);
    check("R1 sdo", sdo_o, 0);
  endtask

  task automatic t_shift_latch();
    logic [CH-1:0] rd;
    stat_sel_i = 1'b0;
    write_word(16'hA5C3);
    pulse_lat();
    check("R3 drv after latch", drv_o, 32'hA5C3);
    read_word(rd);
    check("R2 readback order", rd, 32'hA5C3);
    check("R4 keep when select low", rd, 32'hA5C3);
  endtask

  task automatic t_status();
    logic [CH-1:0] rd;
    stat_sel_i = 1'b1;
    write_word(16'h00FF);
    pulse_lat();
    check("R3 drv second pattern", drv_o, 32'h00FF);
    read_word(rd);
    check("R4 flag word", rd, 32'h002D);
    stat_sel_i = 1'b0;
  endtask

  task automatic t_tap();
    blank_mode_i = 1'b0; blank_i = 1'b0;
    write_word(16'h0080); gap(4);
    check("R5 bit7 tap high", sdo_o, 1);
    blank_i = 1'b1; gap(4);
    check("R5 bit15 tap blank high", sdo_o, 0);
    write_word(16'h8000);
    blank_i = 1'b0; gap(4);
    check("R5 bit7 tap low", sdo_o, 0);
    blank_i = 1'b1; gap(4);
    check("R5 bit15 tap", sdo_o, 1);
    blank_mode_i = 1'b1; blank_i = 1'b0; gap(4);
    check("R5 mode1 uses bit15", sdo_o, 1);
  endtask

  task automatic t_blank();
    write_word(16'h3C5A);
    pulse_lat();
    check("R6 enabled", drv_o, 32'h3C5A);
    blank_i = 1'b1; gap(5);
    check("R6 blanked", drv_o, 0);
    blank_i = 1'b0; gap(5);
    check("R6 restored", drv_o, 32'h3C5A);
    blank_mode_i = 1'b0; blank_i = 1'b1; gap(5);
    check("R6 mode0 blank ignored", drv_o, 32'h3C5A);
    blank_mode_i = 1'b1; blank_i = 1'b0; gap(5);
  endtask

  task automatic t_psave();
    write_word(16'h0000);
    stat_sel_i = 1'b1;
    pulse_lat();
    check("R7 psave set", psave_o, 1);
    check("R7 drv all off", drv_o, 0);
    pulse_lat();
    check("R7 nonzero latch clears", psave_o, 0);
    check("R4 flags to outputs", drv_o, 32'h002D);
    stat_sel_i = 1'b0;
    write_word(16'h0000);
    pulse_lat();
    check("R7 psave set again", psave_o, 1);
    shift_bit(1'b0);
    check("R7 sclk clears", psave_o, 0);
  endtask

  task automatic t_single_edge();
    logic [CH-1:0] rd;
    write_word(16'h0000);
    sdi_i = 1'b1; sclk_i = 1'b1; gap(40);
    sclk_i = 1'b0; sdi_i = 1'b0; gap(4);
    read_word(rd);
    check("R8 one shift per edge", rd, 32'h0001);
  endtask

  initial begin
    gap(5);
    t_reset();
    rst = 1'b0;
    gap(3);
    t_reset();
    t_shift_latch();
    t_status();
    t_tap();
    t_blank();
    t_psave();
    t_single_edge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule